// File: doc/BRIEF.md
# I2C Controller Status and Interrupt Unit

This unit sits beside the bus engine of an I2C master controller. The bus engine reports events as one-cycle pulses: transmit ready, receive ready, access ready, no-acknowledge, arbitration lost, receive overrun and transmit underflow. The unit holds each event as a sticky flag until software clears it by writing a one to that flag. It also shows a live bus-busy level.

Five of the events can be enabled as interrupt sources. A single interrupt line is raised while any enabled flag is pending. A read-only vector register gives the pending enabled cause with the smallest code. Reading the vector also clears that cause, so an interrupt handler can service events one at a time by reading the vector repeatedly.

Software reaches the unit through a simple 16-bit register port with a read strobe and a write strobe. Read data is registered and appears on the cycle after the strobe.

Top module: `i2c_irq_status`

## Requirements
- R1: After reset, every sticky flag is 0, the enable register is 0, `irq` is low and `reg_rdata` is 0.
- R2: A pulse on an event input sets its sticky status bit on the next clock edge. The bit positions are: arbitration lost 0, no-acknowledge 1, access ready 2, receive ready 3, transmit ready 4, transmit underflow 10, receive overrun 11. The bit stays set until it is cleared.
- R3: A write to offset 0x08 clears each sticky bit whose data bit is 1. Data bits that are 0 leave their sticky bits unchanged.
- R4: Status bit 12 always reflects the `bus_busy` input as a live level. Writes to the status register have no effect on bit 12.
- R5: The enable register at offset 0x04 stores data bits 4:0, which are in the same positions as the five interrupt events. Bits 15:5 of this register read as 0.
- R6: `irq` is high exactly when some status bit in 4:0 is set and its enable bit is also set. It changes in the same cycle as the flag or enable register it depends on.
- R7: A read of offset 0x0C returns 0 when no enabled event is pending. Otherwise it returns the smallest pending code, where code = status bit position + 1: 1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready, 5 transmit ready. Overrun and underflow never produce a code.
- R8: A read of the vector clears the status bit whose code it returns. Writes to offset 0x0C have no effect.
- R9: When an event pulse arrives in the same cycle as a clear of its bit, the bit stays set. This holds whether the clear comes from a status write or from a vector read.
- R10: A read of any offset other than 0x04, 0x08 and 0x0C returns 0. Status bits 5 to 9 and 13 to 15 read as 0.
- R11: Read data appears on `reg_rdata` on the cycle after the read strobe. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_arb_lost | input | 1 | Arbitration lost pulse |
| evt_no_ack | input | 1 | No-acknowledge pulse |
| evt_acc_rdy | input | 1 | Access ready pulse |
| evt_rx_rdy | input | 1 | Receive data ready pulse |
| evt_tx_rdy | input | 1 | Transmit data ready pulse |
| evt_rx_ovr | input | 1 | Receive overrun pulse |
| evt_tx_udf | input | 1 | Transmit underflow pulse |
| bus_busy | input | 1 | Live bus-busy level (high from START until STOP) |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The main sweep tries every combination of the 32 enable settings with the 32 patterns of pending interrupt events. For each combination it compares the interrupt line, the vector code, and the status that remains after the vector read. This separates a wrong priority order, a wrong code offset, a missing enable mask and a vector read that clears the wrong flag. Directed patterns add:
- overrun and underflow with every source enabled, which must raise no interrupt and give no code;
- a bus-busy toggle with a status write attempt in between;
- writes of zero bits to the status register;
- same-cycle event and clear collisions through both clear paths;
- unmapped offsets and a write to the vector register.

// File: rtl/i2c_irq_pkg.sv
`timescale 1ns/1ps
package i2c_irq_pkg;
    localparam int REG_W       = 16;
    localparam int NUM_IRQ_EVT = 5;
    localparam int NUM_ERR_EVT = 2;
    localparam int NUM_EVT     = NUM_IRQ_EVT + NUM_ERR_EVT;
    localparam int VEC_W       = $clog2(NUM_IRQ_EVT + 1);
    localparam int POS_TX_UDF  = 10;
    localparam int POS_RX_OVR  = 11;
    localparam int POS_BUSY    = 12;

    typedef struct packed {
        logic [NUM_IRQ_EVT-1:0] ie;
        logic [REG_W-1:0]       rdata;
    } port_state_t;
endpackage

// File: rtl/i2c_irq_flags.sv
`timescale 1ns/1ps
module i2c_irq_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    typedef struct packed {
        logic [N-1:0] flags;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            // a fresh event outranks a clear in the same cycle
            if (set_i[i])      st_d.flags[i] = 1'b1;
            else if (clr_i[i]) st_d.flags[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flags_o[g]); // R2
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !flags_o[g]); // R3
        AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[g] && !set_i[g]) |=> $stable(flags_o[g])); // R2
    end
endmodule

// File: rtl/i2c_irq_prio.sv
`timescale 1ns/1ps
module i2c_irq_prio #(
    parameter int N = 5,
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pending_i,
    output logic [W-1:0] code_o,
    output logic         any_o
);
    always_comb begin
        code_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pending_i[i]) code_o = W'(i + 1);
        end
    end

    assign any_o = |pending_i;

    AST_CODE_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o != '0) |-> pending_i[code_o - 1'b1]); // R7
endmodule

// File: rtl/i2c_irq_status.sv
`timescale 1ns/1ps
module i2c_irq_status
    import i2c_irq_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] OFF_IE   = 'h04,
    parameter logic [ADDR_W-1:0] OFF_STAT = 'h08,
    parameter logic [ADDR_W-1:0] OFF_VEC  = 'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_arb_lost,
    input  logic              evt_no_ack,
    input  logic              evt_acc_rdy,
    input  logic              evt_rx_rdy,
    input  logic              evt_tx_rdy,
    input  logic              evt_rx_ovr,
    input  logic              evt_tx_udf,
    input  logic              bus_busy,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    port_state_t st_d, st_q;

    logic [NUM_EVT-1:0]     evt_vec, flag_vec, clr_vec;
    logic [NUM_IRQ_EVT-1:0] pend_vec, vec_clr;
    logic [VEC_W-1:0]       vec_code;
    logic [REG_W-1:0]       stat_word;
    logic                   sel_ie, sel_stat, sel_vec;

    assign evt_vec  = {evt_rx_ovr, evt_tx_udf, evt_tx_rdy, evt_rx_rdy,
                       evt_acc_rdy, evt_no_ack, evt_arb_lost};
    assign sel_ie   = (reg_addr == OFF_IE);
    assign sel_stat = (reg_addr == OFF_STAT);
    assign sel_vec  = (reg_addr == OFF_VEC);
    assign pend_vec = flag_vec[NUM_IRQ_EVT-1:0] & st_q.ie;

    i2c_irq_flags #(.N(NUM_EVT)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (evt_vec),
        .clr_i   (clr_vec),
        .flags_o (flag_vec)
    );

    i2c_irq_prio #(.N(NUM_IRQ_EVT), .W(VEC_W)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pend_vec),
        .code_o    (vec_code),
        .any_o     (irq)
    );

    always_comb begin
        stat_word                          = '0;
        stat_word[NUM_IRQ_EVT-1:0]         = flag_vec[NUM_IRQ_EVT-1:0];
        stat_word[POS_TX_UDF]              = flag_vec[NUM_IRQ_EVT];
        stat_word[POS_RX_OVR]              = flag_vec[NUM_IRQ_EVT+1];
        stat_word[POS_BUSY]                = bus_busy;
    end

    always_comb begin
        vec_clr = '0;
        if (reg_rd && sel_vec && vec_code != '0)
            vec_clr[vec_code - 1'b1] = 1'b1;
        clr_vec = '0;
        if (reg_wr && sel_stat)
            clr_vec = {reg_wdata[POS_RX_OVR], reg_wdata[POS_TX_UDF],
                       reg_wdata[NUM_IRQ_EVT-1:0]};
        clr_vec[NUM_IRQ_EVT-1:0] = clr_vec[NUM_IRQ_EVT-1:0] | vec_clr;
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr && sel_ie)
            st_d.ie = reg_wdata[NUM_IRQ_EVT-1:0];
        if (reg_rd) begin
            st_d.rdata = '0;
            if (sel_ie)        st_d.rdata[NUM_IRQ_EVT-1:0] = st_q.ie;
            else if (sel_stat) st_d.rdata = stat_word;
            else if (sel_vec)  st_d.rdata[VEC_W-1:0] = vec_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;

    AST_VEC_ZERO_IFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd && sel_vec) |-> ((reg_rdata == '0) == !$past(irq))); // R7
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd && !sel_ie && !sel_stat && !sel_vec) |-> (reg_rdata == '0)); // R10
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_rd) |-> $stable(reg_rdata)); // R11
    AST_IE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd && sel_ie) |-> (reg_rdata[REG_W-1:NUM_IRQ_EVT] == '0)); // R5
endmodule

// File: tb/i2c_irq_status_test.sv
`timescale 1ns/1ps
module i2c_irq_status_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt = '0;
    logic        bus_busy = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    i2c_irq_status uut (
        .clk(clk), .rst_n(rst_n),
        .evt_arb_lost(evt[0]), .evt_no_ack(evt[1]), .evt_acc_rdy(evt[2]),
        .evt_rx_rdy(evt[3]), .evt_tx_rdy(evt[4]), .evt_rx_ovr(evt[6]),
        .evt_tx_udf(evt[5]), .bus_busy(bus_busy),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [6:0] m);
        @(negedge clk);
        evt = m;
        @(negedge clk);
        evt = '0;
    endtask

    // status word from event mask: bits 4:0 direct, [5]->10 (underflow), [6]->11 (overrun)
    function automatic logic [15:0] stat_of(input logic [6:0] m, input logic b);
        return {3'b0, b, m[6], m[5], 5'b0, m[4:0]};
    endfunction

    function automatic logic [15:0] exp_vec(input logic [4:0] p);
        for (int i = 0; i < 5; i++) if (p[i]) return 16'(i + 1);
        return 16'd0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 irq", {15'b0, irq}, 16'h0);
        check("R1 rdata", reg_rdata, 16'h0);
        rst_n = 1'b1;
        rd(8'h08, v); check("R1 status", v, 16'h0);
        rd(8'h04, v); check("R1 enable", v, 16'h0);

        // R2: every event lands at its bit and sticks
        pulse(7'h7F);
        repeat (3) @(negedge clk);
        rd(8'h08, v); check("R2 all events", v, stat_of(7'h7F, 1'b0));
        // R3: zero bits leave flags alone, one bits clear
        wr(8'h08, 16'h0000);
        rd(8'h08, v); check("R3 zero write", v, stat_of(7'h7F, 1'b0));
        wr(8'h08, 16'h0815);
        rd(8'h08, v); check("R3 partial clear", v, stat_of(7'h2A, 1'b0));
        wr(8'h08, 16'hFFFF);
        rd(8'h08, v); check("R3 full clear", v, 16'h0);

        // R4: bus busy is live and unaffected by writes
        bus_busy = 1'b1;
        rd(8'h08, v); check("R4 busy high", v, 16'h1000);
        wr(8'h08, 16'h1000);
        rd(8'h08, v); check("R4 busy write ignored", v, 16'h1000);
        bus_busy = 1'b0;
        rd(8'h08, v); check("R4 busy low", v, 16'h0);

        // R5: enable register width
        wr(8'h04, 16'hFFFF);
        rd(8'h04, v); check("R5 enable readback", v, 16'h001F);
        // R7: overrun/underflow give no cause
        pulse(7'h60);
        check("R7 err no irq", {15'b0, irq}, 16'h0);
        rd(8'h0C, v); check("R7 err no code", v, 16'h0);
        wr(8'h08, 16'hFFFF);

        // R10: unmapped reads, R8 write to vector ignored
        pulse(7'h04);
        wr(8'h0C, 16'hFFFF);
        rd(8'h08, v); check("R8 vector write ignored", v, 16'h0004);
        rd(8'h00, v); check("R10 offset 0", v, 16'h0);
        rd(8'h10, v); check("R10 offset 0x10", v, 16'h0);
        rd(8'h06, v); check("R10 offset 6", v, 16'h0);
        // R11: read data holds
        repeat (4) @(negedge clk);
        check("R11 hold", reg_rdata, 16'h0);
        wr(8'h08, 16'hFFFF);

        // R9: event beats status write clear
        pulse(7'h10);
        @(negedge clk);
        reg_addr = 8'h08; reg_wdata = 16'h0010; reg_wr = 1'b1; evt = 7'h10;
        @(negedge clk);
        reg_wr = 1'b0; evt = '0;
        rd(8'h08, v); check("R9 event beats write", v, 16'h0010);
        // R9: event beats vector read clear
        @(negedge clk);
        reg_addr = 8'h0C; reg_rd = 1'b1; evt = 7'h10;
        @(negedge clk);
        reg_rd = 1'b0; evt = '0;
        check("R9 vector code", reg_rdata, 16'd5);
        rd(8'h08, v); check("R9 event beats vector read", v, 16'h0010);

        // R6/R7/R8: exhaustive enable x pending sweep
        for (int e = 0; e < 32; e++) begin
            for (int p = 0; p < 32; p++) begin
                logic [4:0] pe;
                logic [15:0] ev;
                pe = 5'(p) & 5'(e);
                ev = exp_vec(pe);
                wr(8'h08, 16'hFFFF);
                wr(8'h04, 16'(e));
                pulse(7'(p));
                check("R6 irq level", {15'b0, irq}, {15'b0, |pe});
                rd(8'h0C, v); check("R7 vector code", v, ev);
                rd(8'h08, v);
                if (ev != 0)
                    check("R8 read clears cause", v, 16'(5'(p) & ~(5'd1 << (ev - 1))));
                else
                    check("R8 no cause no clear", v, 16'(p));
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule